// File: doc/BRIEF.md
# Three-Phase Gate Interlock and Dead-Time Generator

This block sits between a PWM generator and the gate drivers of a three-phase inverter. For each phase it accepts a high-side request that is asserted high and a low-side request that is asserted low. All phases also share one enable that is asserted high; when it is low, the whole bridge is shut down. From these inputs the block produces two registered gate-enable bits per phase. The two switches of a leg can never conduct together. Whenever conduction passes from one switch of a leg to the other, both switches stay off for a programmable number of clock cycles.

All inputs may be asynchronous to the clock. They pass through a parameterised synchronizer chain. After that, a small decoder per phase turns the request pair into a wanted side: high, low or none. A leg sequencer then applies the dead time and registers the gate enables. A phase is decoded to "none" in three cases: both sides are requested, neither side is requested, or the shared enable is low. The dead time is enforced from the moment the previous switch turned off. If the new request arrives later than that, the new switch turns on with no added delay.

Top module: `inv_gate_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every `gate_hi` and `gate_lo` bit is 0, whatever the inputs.
- R2: When `run_n` has been 0 for SYNC_STAGES+1 clock edges, every gate output is 0, whatever the request inputs are.
- R3: With `run_n`=1, a phase whose `hs_req` bit is 1 and whose `ls_req_n` bit is 0 (both sides requested) has both gate outputs at 0.
- R4: With `run_n`=1, a phase whose `hs_req` bit is 0 and whose `ls_req_n` bit is 1 (no side requested) has both gate outputs at 0.
- R5: With `run_n`=1, `hs_req`=0 with `ls_req_n`=0 drives only `gate_lo` of that phase. `hs_req`=1 with `ls_req_n`=1 drives only `gate_hi`. Starting from an idle leg, the gate rises SYNC_STAGES+1 clock edges after the inputs are applied.
- R6: When a leg hands conduction from one side to the other, the outgoing gate falls SYNC_STAGES+1 edges after the input change. Both gates then stay 0 for exactly DEAD_CYC cycles before the incoming gate rises. This holds when both request edges fall in the same cycle, including when one signal drives both inputs of the phase.
- R7: If the incoming request arrives more than DEAD_CYC cycles after the outgoing gate fell, the incoming gate rises SYNC_STAGES+1 edges after that request, with no added delay.
- R8: Phase bit 0, bit 1 and bit 2 are decoded and sequenced independently of each other; `run_n` is common to all of them.
- R9: In no cycle are `gate_hi` and `gate_lo` of the same phase both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Shared enable; 0 shuts every leg down |
| hs_req | input | NPH | High-side request per phase, active high |
| ls_req_n | input | NPH | Low-side request per phase, active low |
| gate_hi | output | NPH | High-side gate enable per phase |
| gate_lo | output | NPH | Low-side gate enable per phase |

## Verification
Two functions of a leg can fall in the same cycle: the turn-off of the outgoing switch, and the decode of a request for the opposite switch. The interlock decode could let both through, and the dead-time path could be skipped. The bench provokes this by flipping both request bits of a phase on the same clock, once with independent inputs and once with both inputs tied to one signal. It then samples the gates at the turn-off edge, one cycle before the end of the dead window, and at the end of the window. A second case moves the two edges further apart than the dead time, to confirm that no delay is added.

// File: rtl/invgate_pkg.sv
package invgate_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;
endpackage

// File: rtl/invgate_sync.sv
module invgate_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/invgate_decode.sv
module invgate_decode (
  input  logic en,
  input  logic hs,
  input  logic ls_n,
  output logic want_hi,
  output logic want_lo
);
  logic ls;
  assign ls = ~ls_n;

  always_comb begin
    want_hi = 1'b0;
    want_lo = 1'b0;
    if (en) begin
      // conflicting or empty requests leave the leg floating
      want_hi = hs & ~ls;
      want_lo = ls & ~hs;
    end
  end
endmodule

// File: rtl/invgate_leg.sv
module invgate_leg
  import invgate_pkg::*;
#(
  parameter int DEAD_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic want_hi,
  input  logic want_lo,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] GAP_SAT = CW'(DEAD_CYC);

  side_e         last_q, last_d;
  logic [CW-1:0] gap_q, gap_d;
  logic          hi_q, lo_q, hi_d, lo_d;
  logic          gap_ok;

  assign gap_ok = (gap_q >= GAP_SAT);

  always_comb begin
    hi_d   = want_hi && !lo_q && ((last_q == SIDE_HI) || gap_ok);
    lo_d   = want_lo && !hi_q && ((last_q == SIDE_LO) || gap_ok);
    last_d = hi_d ? SIDE_HI : (lo_d ? SIDE_LO : last_q);
    if (hi_d || lo_d)       gap_d = '0;
    else if (gap_ok)        gap_d = gap_q;
    else                    gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      last_q <= SIDE_NONE;
      gap_q  <= GAP_SAT;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      last_q <= last_d;
      gap_q  <= gap_d;
    end
  end

  assign gate_hi = hi_q;
  assign gate_lo = lo_q;
endmodule

// File: rtl/inv_gate_ctrl.sv
module inv_gate_ctrl #(
  parameter int NPH         = 3,
  parameter int DEAD_CYC    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_n,
  input  logic [NPH-1:0] hs_req,
  input  logic [NPH-1:0] ls_req_n,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  localparam int SW = 1 + 2 * NPH;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, {NPH{1'b0}}, {NPH{1'b1}}};

  logic [SW-1:0]  raw_bus, sync_bus;
  logic           run_s;
  logic [NPH-1:0] hs_s, ls_n_s;

  assign raw_bus = {run_n, hs_req, ls_req_n};

  invgate_sync #(
    .W       (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_bus),
    .q   (sync_bus)
  );

  assign {run_s, hs_s, ls_n_s} = sync_bus;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic want_hi, want_lo;

    invgate_decode u_dec (
      .en      (run_s),
      .hs      (hs_s[p]),
      .ls_n    (ls_n_s[p]),
      .want_hi (want_hi),
      .want_lo (want_lo)
    );

    invgate_leg #(
      .DEAD_CYC (DEAD_CYC)
    ) u_leg (
      .clk     (clk),
      .rst     (rst),
      .want_hi (want_hi),
      .want_lo (want_lo),
      .gate_hi (gate_hi[p]),
      .gate_lo (gate_lo[p])
    );
  end
endmodule

// File: rtl/invgate_checker.sv
module invgate_checker #(
  parameter int NPH         = 3,
  parameter int DEAD_CYC    = 18,
  parameter int SYNC_STAGES = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           run_n,
  input logic [NPH-1:0] hs_req,
  input logic [NPH-1:0] ls_req_n,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo
);
  localparam int LAT = SYNC_STAGES + 1;
  localparam int LW  = $clog2(LAT + 2);
  localparam int GW  = $clog2(DEAD_CYC + 2);

  logic [LW-1:0] stop_cnt;

  always_ff @(posedge clk) begin
    if (rst)                     stop_cnt <= '0;
    else if (run_n)              stop_cnt <= '0;
    else if (stop_cnt < LW'(LAT)) stop_cnt <= stop_cnt + 1'b1;
  end

  assert_shutdown_blanks_R2: assert property (@(posedge clk) disable iff (rst)
    (stop_cnt >= LW'(LAT)) |-> (gate_hi == '0 && gate_lo == '0));

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    logic [LW-1:0] clash_cnt;
    logic [GW-1:0] since_hi, since_lo;

    always_ff @(posedge clk) begin
      if (rst) begin
        clash_cnt <= '0;
        since_hi  <= GW'(DEAD_CYC);
        since_lo  <= GW'(DEAD_CYC);
      end else begin
        if (!(hs_req[p] && !ls_req_n[p]))   clash_cnt <= '0;
        else if (clash_cnt < LW'(LAT))      clash_cnt <= clash_cnt + 1'b1;
        if (gate_hi[p])                     since_hi <= '0;
        else if (since_hi < GW'(DEAD_CYC))  since_hi <= since_hi + 1'b1;
        if (gate_lo[p])                     since_lo <= '0;
        else if (since_lo < GW'(DEAD_CYC))  since_lo <= since_lo + 1'b1;
      end
    end

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[p] && gate_lo[p]));

    assert_both_req_off_R3: assert property (@(posedge clk) disable iff (rst)
      (clash_cnt >= LW'(LAT)) |-> (!gate_hi[p] && !gate_lo[p]));

    assert_dead_before_lo_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[p]) |-> (since_hi >= GW'(DEAD_CYC)));

    assert_dead_before_hi_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p]) |-> (since_lo >= GW'(DEAD_CYC)));
  end
endmodule

bind inv_gate_ctrl invgate_checker #(
  .NPH         (NPH),
  .DEAD_CYC    (DEAD_CYC),
  .SYNC_STAGES (SYNC_STAGES)
) u_invgate_checker (
  .clk      (clk),
  .rst      (rst),
  .run_n    (run_n),
  .hs_req   (hs_req),
  .ls_req_n (ls_req_n),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo)
);

// File: tb/test_inv_gate_ctrl.sv
module test_inv_gate_ctrl;
  localparam int NPH   = 3;
  localparam int DEAD  = 18;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + 1;
  localparam int NVEC  = 8;

  // {run_n, hs_req[2:0], ls_req_n[2:0], exp_hi[2:0], exp_lo[2:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1_001_111_001_000,  // R5 high side of bit 0 only
    13'b1_000_110_000_001,  // R5 low side of bit 0 only
    13'b1_111_000_000_000,  // R3 both requested everywhere
    13'b1_000_111_000_000,  // R4 nothing requested
    13'b1_101_101_101_010,  // R8 mixed per phase
    13'b0_101_101_000_000,  // R2 shutdown overrides
    13'b1_010_011_010_100,  // R8 another mix
    13'b1_100_000_000_011   // R3 on bit 2, low on bits 0 and 1
  };

  logic clk = 1'b0;
  logic rst;
  logic run_n;
  logic [NPH-1:0] hs_req, ls_req_n;
  logic [NPH-1:0] gate_hi, gate_lo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inv_gate_ctrl #(
    .NPH (NPH), .DEAD_CYC (DEAD), .SYNC_STAGES (SYNC)
  ) i_inv_gate_ctrl (
    .clk (clk), .rst (rst), .run_n (run_n),
    .hs_req (hs_req), .ls_req_n (ls_req_n),
    .gate_hi (gate_hi), .gate_lo (gate_lo)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got hi/lo %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    run_n = 1'b1;
    hs_req = '1;
    ls_req_n = '1;
    edges(6);
    check("R1 in reset", {gate_hi, gate_lo}, 6'b0);
    rst = 1'b0;
    edges(0);
    check("R1 after release", {gate_hi, gate_lo}, 6'b0);
    hs_req = '0;
    edges(DEAD + 6);

    for (int i = 0; i < NVEC; i++) begin
      {run_n, hs_req, ls_req_n} = VEC[i][12:6];
      edges(DEAD + LAT + 4);
      check($sformatf("table row %0d (R2-R5,R8)", i), {gate_hi, gate_lo}, VEC[i][5:0]);
    end

    // R5 latency from idle
    run_n = 1'b1; hs_req = '0; ls_req_n = '1;
    edges(DEAD + 6);
    hs_req = 3'b001; ls_req_n = 3'b111;
    edges(LAT - 1);
    check("R5 before latency", {gate_hi, gate_lo}, 6'b000_000);
    edges(1);
    check("R5 at latency", {gate_hi, gate_lo}, 6'b001_000);

    // R6 coincident handover high -> low on bit 0
    edges(DEAD + 4);
    hs_req = 3'b000; ls_req_n = 3'b110;
    edges(LAT);
    check("R6 outgoing off", {gate_hi, gate_lo}, 6'b000_000);
    edges(DEAD - 1);
    check("R6 dead window held", {gate_hi, gate_lo}, 6'b000_000);
    edges(1);
    check("R6 incoming on", {gate_hi, gate_lo}, 6'b000_001);

    // R6 with both inputs of bit 1 tied to one signal
    hs_req = 3'b000; ls_req_n = 3'b101;
    edges(DEAD + 8);
    check("R6 tied low side", {gate_hi, gate_lo}, 6'b000_010);
    hs_req = 3'b010; ls_req_n = 3'b111;
    edges(LAT);
    check("R6 tied off", {gate_hi, gate_lo}, 6'b000_000);
    edges(DEAD - 1);
    check("R6 tied dead held", {gate_hi, gate_lo}, 6'b000_000);
    edges(1);
    check("R6 tied high on", {gate_hi, gate_lo}, 6'b010_000);

    // R7 edges further apart than the dead time
    hs_req = 3'b000;
    edges(DEAD + 6);
    check("R7 idle", {gate_hi, gate_lo}, 6'b000_000);
    ls_req_n = 3'b101;
    edges(LAT - 1);
    check("R7 before latency", {gate_hi, gate_lo}, 6'b000_000);
    edges(1);
    check("R7 no added delay", {gate_hi, gate_lo}, 6'b000_010);

    // R2 shutdown during an active leg, exact latency
    run_n = 1'b0;
    edges(LAT);
    check("R2 shutdown latency", {gate_hi, gate_lo}, 6'b000_000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule